// File: doc/BRIEF.md
# Privileged-Ring Call Stack Switch Sequencer

This block carries out the stack hand-over that accompanies a call through a gate into a more privileged ring. A controller starts it with the target ring, the caller's stack segment, stack pointer, code segment and instruction pointer, and the parameter count held in the gate. The sequencer reads the target ring's stack pointer and stack segment from the task state segment over a word-wide read port. It then builds the return frame on the new stack over a word-wide write port. This frame holds the caller's stack segment and stack pointer, a copy of the gate's parameters taken from the caller's stack, and the caller's code segment and instruction pointer.

Every memory access is a request held until the memory answers with a ready. When the last word is written, the block pulses a completion flag and presents the new stack segment and the final stack pointer. Ring 3 has no stack slot in the task state segment, so a request that targets it is refused at once with an error pulse. The controller must only start the block on a call that changes privilege.

Top module: `ring_call_stack_seq`

## Requirements
- R1: While reset is asserted and after it, with no start, `busy`, `done`, `err`, `rd_req` and `wr_req` are all low.
- R2: A start with `tgt_ring` = 3 while idle raises `err` for exactly one cycle, on the cycle after start. It makes no memory request and leaves `busy` low.
- R3: For target ring r (0..2), the block first reads the stack pointer word at `tss_base + 4 + 8*r` and then the segment word at `tss_base + 8 + 8*r`. The new SS is bits 15:0 of the segment word.
- R4: With T the stack pointer read from the table, the first write stores the caller's SS zero-extended to 32 bits at T-4. The second stores the caller's ESP at T-8. Every push lowers the stack pointer by 4 before it writes.
- R5: With count n (5 bits, 0..31) from the gate, the block copies n words. It reads `old_esp + 4*(n-1)` down to `old_esp` and pushes each word as soon as it has been read, so the parameters keep their layout on the new stack. When n = 0 there are no parameter reads.
- R6: After the parameters, the block pushes the caller's CS, zero-extended, and then the caller's EIP.
- R7: `done` is high for one cycle, on the cycle after the handshake of the EIP write. At that point `new_esp` = T - 4*(4+n), which is the address of the saved EIP, and `new_ss` holds the new SS.
- R8: A pending read or write request stays asserted with a stable address, and for writes stable data, until its ready is seen.
- R9: A start that arrives while `busy` is high is ignored and does not change the access sequence or the results.
- R10: The block never asserts `rd_req` and `wr_req` in the same cycle, and it makes no request while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a stack switch (accepted only when idle) |
| tgt_ring | input | 2 | Privilege ring being entered |
| old_ss | input | 16 | Caller's stack segment selector |
| old_esp | input | 32 | Caller's stack pointer |
| old_cs | input | 16 | Caller's code segment selector |
| old_eip | input | 32 | Caller's return instruction pointer |
| parm_cnt | input | 5 | Number of parameter words to copy |
| tss_base | input | 32 | Byte address of the task state segment |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_data | input | 32 | Read data, taken when rd_ready is high |
| rd_ready | input | 1 | Read completes at this clock edge |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write completes at this clock edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused ring-3 request |
| new_ss | output | 16 | New stack segment selector |
| new_esp | output | 32 | Final stack pointer on the new stack |

## Verification
A wrong stack pointer or state shows up at the write port on the first push that follows it, as a wrong address or wrong data in that handshake cycle. A wrong parameter counter shows up as a missing or extra parameter read, or an early or late CS write. The bench compares every read and write handshake, in order, against a behavioural model of the frame, and compares `done` and `err` on every clock. Any divergence is therefore reported in the same cycle it reaches the ports. Random ready stalls expose any request that does not hold its address and data steady while it waits.

// File: rtl/ring_call_stack_pkg.sv
package ring_call_stack_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GET_SP,
    ST_GET_SEG,
    ST_PUT_SS,
    ST_PUT_SP,
    ST_PRM_RD,
    ST_PRM_WR,
    ST_PUT_CS,
    ST_PUT_IP
  } seq_state_e;
endpackage

// File: rtl/stack_ptr_track.sv
module stack_ptr_track #(
  parameter int WW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [WW-1:0] load_val,
  input  logic          dec_en,
  output logic [WW-1:0] sp_q
);
  logic [WW-1:0] sp_d;

  always_comb begin
    sp_d = sp_q;
    if (load_en)     sp_d = load_val;
    else if (dec_en) sp_d = sp_q - WW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sp_q <= '0;
    else if (load_en || dec_en) sp_q <= sp_d;
  end
endmodule

// File: rtl/parm_count.sv
module parm_count #(
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [CNTW-1:0] load_val,
  input  logic            dec_en,
  output logic [CNTW-1:0] cnt_q,
  output logic            is_zero,
  output logic            is_last
);
  logic [CNTW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)     cnt_d = load_val;
    else if (dec_en) cnt_d = cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load_en || dec_en) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);
  assign is_last = (cnt_q == CNTW'(1));
endmodule

// File: rtl/ring_call_stack_seq.sv
module ring_call_stack_seq
  import ring_call_stack_pkg::*;
#(
  parameter int WW    = 32,
  parameter int SELW  = 16,
  parameter int CNTW  = 5,
  parameter int RINGW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RINGW-1:0] tgt_ring,
  input  logic [SELW-1:0]  old_ss,
  input  logic [WW-1:0]    old_esp,
  input  logic [SELW-1:0]  old_cs,
  input  logic [WW-1:0]    old_eip,
  input  logic [CNTW-1:0]  parm_cnt,
  input  logic [WW-1:0]    tss_base,
  output logic             rd_req,
  output logic [WW-1:0]    rd_addr,
  input  logic [WW-1:0]    rd_data,
  input  logic             rd_ready,
  output logic             wr_req,
  output logic [WW-1:0]    wr_addr,
  output logic [WW-1:0]    wr_data,
  input  logic             wr_ready,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [SELW-1:0]  new_ss,
  output logic [WW-1:0]    new_esp
);
  localparam int WB        = WW / 8;
  localparam int SLOT      = 2 * WB;
  localparam int SP_OFS    = WB;
  localparam int SEG_OFS   = 2 * WB;
  localparam logic [RINGW-1:0] NO_SLOT_RING = '1;

  seq_state_e state_q, state_d;
  logic [RINGW-1:0] ring_q;
  logic [SELW-1:0]  oss_q, ocs_q, nss_q;
  logic [WW-1:0]    oesp_q, oeip_q, base_q, prm_q;
  logic             done_q, done_d, err_q, err_d;
  logic             accept, refuse, rd_hs, wr_hs;
  logic             sp_load, cnt_zero, cnt_last;
  logic [CNTW-1:0]  cnt_q;
  logic [WW-1:0]    sp_q, slot_addr;

  assign accept = start && (state_q == ST_IDLE);
  assign refuse = accept && (tgt_ring == NO_SLOT_RING);
  assign rd_hs  = rd_req && rd_ready;
  assign wr_hs  = wr_req && wr_ready;
  assign sp_load = (state_q == ST_GET_SP) && rd_hs;

  stack_ptr_track #(.WW(WW), .STEP(WB)) u_sp (
    .clk(clk), .rst_n(rst_n), .load_en(sp_load), .load_val(rd_data),
    .dec_en(wr_hs), .sp_q(sp_q)
  );

  parm_count #(.CNTW(CNTW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_en(accept), .load_val(parm_cnt),
    .dec_en((state_q == ST_PRM_WR) && wr_hs), .cnt_q(cnt_q),
    .is_zero(cnt_zero), .is_last(cnt_last)
  );

  // next state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (refuse)      err_d   = 1'b1;
        else if (accept) state_d = ST_GET_SP;
      end
      ST_GET_SP:  if (rd_hs) state_d = ST_GET_SEG;
      ST_GET_SEG: if (rd_hs) state_d = ST_PUT_SS;
      ST_PUT_SS:  if (wr_hs) state_d = ST_PUT_SP;
      ST_PUT_SP:  if (wr_hs) state_d = cnt_zero ? ST_PUT_CS : ST_PRM_RD;
      ST_PRM_RD:  if (rd_hs) state_d = ST_PRM_WR;
      ST_PRM_WR:  if (wr_hs) state_d = cnt_last ? ST_PUT_CS : ST_PRM_RD;
      ST_PUT_CS:  if (wr_hs) state_d = ST_PUT_IP;
      ST_PUT_IP: begin
        if (wr_hs) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // caller context, captured on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= '0; oss_q <= '0; ocs_q <= '0;
      oesp_q <= '0; oeip_q <= '0; base_q <= '0;
    end else if (accept) begin
      ring_q <= tgt_ring; oss_q <= old_ss; ocs_q <= old_cs;
      oesp_q <= old_esp;  oeip_q <= old_eip; base_q <= tss_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  nss_q <= '0;
    else if ((state_q == ST_GET_SEG) && rd_hs)   nss_q <= rd_data[SELW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  prm_q <= '0;
    else if ((state_q == ST_PRM_RD) && rd_hs)    prm_q <= rd_data;
  end

  // memory ports
  assign slot_addr = base_q + WW'(ring_q) * WW'(SLOT);

  always_comb begin
    rd_req  = 1'b0;
    rd_addr = '0;
    unique case (state_q)
      ST_GET_SP:  begin rd_req = 1'b1; rd_addr = slot_addr + WW'(SP_OFS);  end
      ST_GET_SEG: begin rd_req = 1'b1; rd_addr = slot_addr + WW'(SEG_OFS); end
      ST_PRM_RD:  begin
        rd_req  = 1'b1;
        rd_addr = oesp_q + (WW'(cnt_q) - WW'(1)) * WW'(WB);
      end
      default: ;
    endcase
  end

  always_comb begin
    wr_req  = 1'b1;
    wr_data = '0;
    unique case (state_q)
      ST_PUT_SS: wr_data = WW'(oss_q);
      ST_PUT_SP: wr_data = oesp_q;
      ST_PRM_WR: wr_data = prm_q;
      ST_PUT_CS: wr_data = WW'(ocs_q);
      ST_PUT_IP: wr_data = oeip_q;
      default:   wr_req  = 1'b0;
    endcase
  end

  assign wr_addr = sp_q - WW'(WB);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign new_ss  = nss_q;
  assign new_esp = sp_q;
endmodule

// File: rtl/ring_call_stack_chk.sv
module ring_call_stack_chk #(
  parameter int WW    = 32,
  parameter int RINGW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [RINGW-1:0] tgt_ring,
  input logic             busy,
  input logic             rd_req,
  input logic             rd_ready,
  input logic [WW-1:0]    rd_addr,
  input logic             wr_req,
  input logic             wr_ready,
  input logic [WW-1:0]    wr_addr,
  input logic [WW-1:0]    wr_data,
  input logic             done,
  input logic             err
);
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_req && wr_ready));

  assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start && !busy && (tgt_ring == '1)));

  assert_err_no_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

bind ring_call_stack_seq ring_call_stack_chk #(.WW(WW), .RINGW(RINGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tgt_ring(tgt_ring), .busy(busy),
  .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done), .err(err)
);

// File: tb/tb_ring_call_stack_seq.sv
module tb_ring_call_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  tgt_ring;
  logic [15:0] old_ss, old_cs, new_ss;
  logic [31:0] old_esp, old_eip, tss_base;
  logic [4:0]  parm_cnt;
  logic        rd_req, rd_ready, wr_req, wr_ready;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data, new_esp;
  logic        busy, done, err;

  always #10 clk = ~clk;

  ring_call_stack_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_ring(tgt_ring),
    .old_ss(old_ss), .old_esp(old_esp), .old_cs(old_cs), .old_eip(old_eip),
    .parm_cnt(parm_cnt), .tss_base(tss_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .err(err), .new_ss(new_ss), .new_esp(new_esp)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_rd[$];
  logic [63:0] exp_wr[$];
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic        mon_on = 1'b0;
  logic        done_pend = 1'b0, err_pend = 1'b0;
  logic        stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_esp;
  logic [15:0] exp_ss;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference model, evaluated every cycle away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      chk(done == done_pend, "R7 done timing", 64'(done), 64'(done_pend));
      if (done_pend) begin
        chk(new_esp == exp_esp, "R7 final esp", 64'(new_esp), 64'(exp_esp));
        chk(new_ss == exp_ss, "R3 new ss", 64'(new_ss), 64'(exp_ss));
      end
      chk(err == err_pend, "R2 err timing", 64'(err), 64'(err_pend));
      done_pend = 1'b0;
      err_pend  = start && !busy && (tgt_ring == 2'd3);
      if (rd_req && wr_req) chk(1'b0, "R10 both ports", 64'd1, 64'd0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_ready = stall ? lfsr[0] : 1'b1;
      wr_ready = stall ? lfsr[3] : 1'b1;
      rd_data  = mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
      if (rd_req && rd_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, "R10 stray read", 64'(rd_addr), 64'd0);
        else begin
          logic [31:0] ea;
          ea = exp_rd.pop_front();
          chk(rd_addr == ea, "R3/R5 read address", 64'(rd_addr), 64'(ea));
        end
      end
      if (wr_req && wr_ready) begin
        if (exp_wr.size() == 0) chk(1'b0, "R10 stray write", {wr_addr, wr_data}, 64'd0);
        else begin
          logic [63:0] ew;
          ew = exp_wr.pop_front();
          chk({wr_addr, wr_data} == ew, "R4/R5/R6 write addr,data", {wr_addr, wr_data}, ew);
          mem[wr_addr] = wr_data;
          if (exp_wr.size() == 0) done_pend = 1'b1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic drive_start(input logic [1:0] r, input logic [15:0] ss, input logic [31:0] esp,
                             input logic [15:0] cs, input logic [31:0] eip, input logic [4:0] n,
                             input logic [31:0] base);
    @(posedge clk); #5;
    start = 1'b1; tgt_ring = r; old_ss = ss; old_esp = esp; old_cs = cs;
    old_eip = eip; parm_cnt = n; tss_base = base;
    @(posedge clk); #5;
    start = 1'b0;
  endtask

  task automatic run_call(input logic [1:0] r, input logic [15:0] ss, input logic [31:0] esp,
                          input logic [15:0] cs, input logic [31:0] eip, input int n,
                          input logic [31:0] base, input logic [31:0] top,
                          input logic [15:0] nss, input bit poke_busy);
    logic [31:0] sp;
    mem[base + 32'd4 + 32'd8 * 32'(r)] = top;
    mem[base + 32'd8 + 32'd8 * 32'(r)] = {16'hBEEF, nss};
    for (int k = 0; k < n; k++) mem[esp + 32'(4 * k)] = 32'h5A00_0000 + 32'(k * 32'h101) + eip;
    exp_rd.push_back(base + 32'd4 + 32'd8 * 32'(r));
    exp_rd.push_back(base + 32'd8 + 32'd8 * 32'(r));
    sp = top;
    sp -= 4; exp_wr.push_back({sp, 16'h0, ss});
    sp -= 4; exp_wr.push_back({sp, esp});
    for (int k = n - 1; k >= 0; k--) begin
      exp_rd.push_back(esp + 32'(4 * k));
      sp -= 4; exp_wr.push_back({sp, mem[esp + 32'(4 * k)]});
    end
    sp -= 4; exp_wr.push_back({sp, 16'h0, cs});
    sp -= 4; exp_wr.push_back({sp, eip});
    exp_esp = sp;
    exp_ss  = nss;
    drive_start(r, ss, esp, cs, eip, 5'(n), base);
    if (poke_busy) begin
      repeat (2) @(posedge clk);
      #5; // R9: second start while busy, would error if accepted
      start = 1'b1; tgt_ring = 2'd3; old_esp = 32'hDEAD_0000; parm_cnt = 5'd7;
      @(posedge clk); #5;
      start = 1'b0;
    end
    while (exp_wr.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(exp_rd.size() == 0, "R5 all reads done", 64'(exp_rd.size()), 64'd0);
    chk(!busy, "R7 idle after done", 64'(busy), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; tgt_ring = '0; old_ss = '0; old_cs = '0;
    old_esp = '0; old_eip = '0; parm_cnt = '0; tss_base = '0;
    rd_ready = 1'b0; wr_ready = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, err, rd_req, wr_req} == 5'b0, "R1 in reset",
        64'({busy, done, err, rd_req, wr_req}), 64'd0);
    @(posedge clk); #5; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, err, rd_req, wr_req} == 5'b0, "R1 after reset",
        64'({busy, done, err, rd_req, wr_req}), 64'd0);
    mon_on = 1'b1;

    // R3 R4 R5 R6 R7: ring 0, three parameters, no stalls
    run_call(2'd0, 16'h002B, 32'h0001_0F00, 16'h0023, 32'h0040_1234, 3,
             32'h0000_8000, 32'h0009_0000, 16'h0010, 1'b0);
    // R5: zero parameters, ring 1
    run_call(2'd1, 16'hFFFF, 32'h0002_0000, 16'hFFF3, 32'hCAFE_F00D, 0,
             32'h0000_9000, 32'h000A_0000, 16'h0041, 1'b0);
    // R8: ring 2, full 31 parameters, random stalls
    stall = 1'b1;
    run_call(2'd2, 16'h003B, 32'h0003_0100, 16'h001B, 32'h0000_7777, 31,
             32'h0000_A000, 32'h000B_0400, 16'h0052, 1'b0);
    // R9: start while busy is ignored
    run_call(2'd0, 16'h0033, 32'h0004_0020, 16'h0013, 32'h1357_9BDF, 1,
             32'h0000_B000, 32'h000C_0000, 16'h0060, 1'b1);
    stall = 1'b0;
    // R2: ring 3 has no slot
    drive_start(2'd3, 16'h0001, 32'h0005_0000, 16'h0002, 32'h0000_0003, 5'd2, 32'h0000_C000);
    #5; chk(!busy, "R2 busy stays low", 64'(busy), 64'd0);
    repeat (5) @(posedge clk);
    chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R2 no access", 64'(busy), 64'd0);
    // R10: quiet while idle with ready high
    repeat (4) @(posedge clk);
    #5; chk(!rd_req && !wr_req, "R10 idle quiet", 64'({rd_req, wr_req}), 64'd0);
    mon_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule